// File: doc/BRIEF.md
# Redundant Bus-Owner Switchover Controller

This controller moves ownership of a shared backplane bus domain from the active host to a powered standby host. The standby host raises a takeover request. The controller then interrupts the current owner and gives it a programmable number of cycles to agree. If the owner agrees in time, the handover is recorded as cooperative. If the window runs out first, the controller takes the bus by force and records the handover as pre-emptive. Both kinds begin the same way and differ only in how the wait ends.

Once the wait is over, the controller quiets every peripheral slot by holding its reset line asserted for a programmable minimum time. Slot power stays on, and each board-select line stays asserted. While the slots are still held in reset, the system-agent role moves to the other host. The slots are then released. A sticky completion flag is set at the end, and writing 1 to its clear input clears it. A build-time option makes the controller quiet the slots by dropping board-select instead, for boards that must be power-cycled.

Top module: `swo_handover_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it goes low, the outputs read as follows: `owner_o`=0 (host A), `irq_o`=0, `slot_rst_o`=all 0, `slot_sel_o`=all 1, `done_o`=0 and `last_forced_o`=0.
- R2: A request taken while idle drives `irq_o` high from the next cycle on. It stays high for one notify cycle plus every wait cycle, and drops in the cycle after consent or timeout.
- R3: If `consent_i` is high during one of the wait cycles, the handover completes with `last_forced_o`=0 and `owner_o` inverted.
- R4: With timeout count N>0, the controller samples consent on exactly N wait cycles. Consent on the N-th cycle still counts as cooperative. With no consent, `irq_o` is high for N+1 cycles and the handover completes with `last_forced_o`=1.
- R5: A timeout count of 0 forces a pre-emptive handover at once, and `irq_o` is high for exactly one cycle.
- R6: Every bit of `slot_rst_o` is high for max(H,1)+1 consecutive cycles, where H is `hold_cfg_i`. `owner_o` changes while the slot resets are still high.
- R7: With the default option (`SEL_QUIESCE`=0), every bit of `slot_sel_o` stays 1 for the whole handover.
- R8: A request that arrives while a handover is in progress is ignored, so ownership changes exactly once per handover.
- R9: `done_o` goes high when a handover completes and stays high until a cycle with `done_clr_i`=1. If completion and clear fall in the same cycle, completion wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Takeover request from the standby host |
| consent_i | input | 1 | Consent from the current owner |
| timeout_cfg_i | input | TMR_W | Number of consent wait cycles; 0 forces an immediate takeover |
| hold_cfg_i | input | HOLD_W | Minimum number of quiesce cycles with slots in reset |
| done_clr_i | input | 1 | Write-1 clear of the done flag |
| irq_o | output | 1 | Interrupt to the current owner |
| slot_rst_o | output | NSLOT | Per-slot reset, active high |
| slot_sel_o | output | NSLOT | Per-slot board select, active high |
| owner_o | output | 1 | Current owner: 0 is host A, 1 is host B |
| last_forced_o | output | 1 | Type of the last handover: 1 is pre-emptive, 0 is cooperative |
| done_o | output | 1 | Sticky completion flag |

## Verification
The assertions assume that the configuration inputs hold steady while a handover is running. They also assume that consent is a short pulse sent by the owner in reply to the interrupt. The stimulus changes `timeout_cfg_i` and `hold_cfg_i` only while the controller is idle, and gives consent for a single cycle inside the wait window. Stray requests are sent only in the middle of a handover, so the single-flip property is tested under the conditions it is meant to cover.

// File: rtl/swo_pkg.sv
package swo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_NOTIFY   = 3'd1,
      ST_WAIT     = 3'd2,
      ST_QUIESCE  = 3'd3,
      ST_TRANSFER = 3'd4,
      ST_RELEASE  = 3'd5,
      ST_DONE     = 3'd6
   } swo_state_e;

   localparam logic OWNER_HOST_A = 1'b0;
endpackage

// File: rtl/swo_countdown.sv
module swo_countdown #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o,
   output logic         one_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   if (W < 1) begin : g_bad_w
      $error("swo_countdown: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (dec_i && cnt_q != '0)
         cnt_q <= cnt_q - ONE;
   end

   assign zero_o = (cnt_q == '0);
   assign one_o  = (cnt_q == ONE);

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      (zero_o && !load_i) |=> zero_o);   // R4
endmodule

// File: rtl/swo_slot_gate.sv
module swo_slot_gate #(
   parameter int NSLOT       = 4,
   parameter bit SEL_QUIESCE = 1'b0
) (
   input  logic             quiet_i,
   output logic [NSLOT-1:0] slot_rst_o,
   output logic [NSLOT-1:0] slot_sel_o
);
   if (NSLOT < 1) begin : g_bad_n
      $error("swo_slot_gate: NSLOT must be at least 1");
   end

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (SEL_QUIESCE) begin : g_power
         assign slot_rst_o[i] = 1'b0;
         assign slot_sel_o[i] = ~quiet_i;
      end else begin : g_reset
         assign slot_rst_o[i] = quiet_i;
         assign slot_sel_o[i] = 1'b1;
      end
   end
endmodule

// File: rtl/swo_handover_ctrl.sv
module swo_handover_ctrl
   import swo_pkg::*;
#(
   parameter int NSLOT       = 4,
   parameter int TMR_W       = 16,
   parameter int HOLD_W      = 8,
   parameter bit SEL_QUIESCE = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic              consent_i,
   input  logic [TMR_W-1:0]  timeout_cfg_i,
   input  logic [HOLD_W-1:0] hold_cfg_i,
   input  logic              done_clr_i,
   output logic              irq_o,
   output logic [NSLOT-1:0]  slot_rst_o,
   output logic [NSLOT-1:0]  slot_sel_o,
   output logic              owner_o,
   output logic              last_forced_o,
   output logic              done_o
);
   localparam logic [NSLOT-1:0] ALL_SLOTS = {NSLOT{1'b1}};

   if (TMR_W < 1 || HOLD_W < 1) begin : g_bad_cfg
      $error("swo_handover_ctrl: counter widths must be at least 1");
   end

   swo_state_e state_q, state_d;
   logic       forced_q, owner_q, last_forced_q, done_q;
   logic       set_forced, set_coop;
   logic       wait_ld, wait_dec, wait_zero, wait_one;
   logic       hold_ld, hold_dec, hold_zero, hold_one;
   logic       quiet;

   swo_countdown #(.W(TMR_W)) u_wait_tmr (
      .clk(clk), .rst(rst),
      .load_i(wait_ld), .load_val_i(timeout_cfg_i), .dec_i(wait_dec),
      .zero_o(wait_zero), .one_o(wait_one)
   );

   swo_countdown #(.W(HOLD_W)) u_hold_tmr (
      .clk(clk), .rst(rst),
      .load_i(hold_ld), .load_val_i(hold_cfg_i), .dec_i(hold_dec),
      .zero_o(hold_zero), .one_o(hold_one)
   );

   always_comb begin
      state_d    = state_q;
      wait_ld    = 1'b0;
      wait_dec   = 1'b0;
      hold_ld    = 1'b0;
      hold_dec   = 1'b0;
      set_forced = 1'b0;
      set_coop   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (req_i) begin
               state_d = ST_NOTIFY;
               wait_ld = 1'b1;
            end
         end
         ST_NOTIFY: begin
            if (wait_zero) begin
               state_d    = ST_QUIESCE;
               set_forced = 1'b1;
               hold_ld    = 1'b1;
            end else begin
               state_d = ST_WAIT;
            end
         end
         ST_WAIT: begin
            if (consent_i) begin
               state_d  = ST_QUIESCE;
               set_coop = 1'b1;
               hold_ld  = 1'b1;
            end else if (wait_one) begin
               state_d    = ST_QUIESCE;
               set_forced = 1'b1;
               hold_ld    = 1'b1;
            end else begin
               wait_dec = 1'b1;
            end
         end
         ST_QUIESCE: begin
            if (hold_zero || hold_one)
               state_d = ST_TRANSFER;
            else
               hold_dec = 1'b1;
         end
         ST_TRANSFER: state_d = ST_RELEASE;
         ST_RELEASE:  state_d = ST_DONE;
         ST_DONE:     state_d = ST_IDLE;
         default:     state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q       <= ST_IDLE;
         forced_q      <= 1'b0;
         owner_q       <= OWNER_HOST_A;
         last_forced_q <= 1'b0;
         done_q        <= 1'b0;
      end else begin
         state_q <= state_d;
         if (set_forced)
            forced_q <= 1'b1;
         else if (set_coop)
            forced_q <= 1'b0;
         if (state_q == ST_QUIESCE && state_d == ST_TRANSFER)
            owner_q <= ~owner_q;
         if (state_q == ST_DONE) begin
            last_forced_q <= forced_q;
            done_q        <= 1'b1;
         end else if (done_clr_i) begin
            done_q <= 1'b0;
         end
      end
   end

   assign quiet = (state_q == ST_QUIESCE) || (state_q == ST_TRANSFER);

   swo_slot_gate #(.NSLOT(NSLOT), .SEL_QUIESCE(SEL_QUIESCE)) u_slots (
      .quiet_i(quiet), .slot_rst_o(slot_rst_o), .slot_sel_o(slot_sel_o)
   );

   assign irq_o         = (state_q == ST_NOTIFY) || (state_q == ST_WAIT);
   assign owner_o       = owner_q;
   assign last_forced_o = last_forced_q;
   assign done_o        = done_q;

   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WAIT && !consent_i && !wait_one) |=> irq_o);   // R2

   AST_COOP_CLASS: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WAIT && consent_i) |=> !forced_q);   // R3

   AST_ZERO_FORCES: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_NOTIFY && wait_zero) |=> (forced_q && !irq_o));   // R5

   if (!SEL_QUIESCE) begin : g_ast_reset_mode
      AST_OWNER_UNDER_RST: assert property (@(posedge clk) disable iff (rst)
         (owner_q != $past(owner_q)) |-> (slot_rst_o == ALL_SLOTS));   // R6
      AST_SEL_KEPT: assert property (@(posedge clk) disable iff (rst)
         quiet |-> (slot_sel_o == ALL_SLOTS));   // R7
   end

   AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_NOTIFY) |-> ($past(state_q) == ST_IDLE));   // R8

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (done_q && !done_clr_i) |=> done_q);   // R9
endmodule

// File: tb/swo_handover_ctrl_tb.sv
module swo_handover_ctrl_tb;
   localparam int NSLOT = 4;
   localparam int TMR_W = 16;
   localparam int HOLD_W = 8;
   localparam logic [NSLOT-1:0] ALL = {NSLOT{1'b1}};

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              req = 1'b0;
   logic              consent = 1'b0;
   logic [TMR_W-1:0]  tcfg = '0;
   logic [HOLD_W-1:0] hcfg = '0;
   logic              dclr = 1'b0;
   logic              irq, owner, last_forced, done;
   logic [NSLOT-1:0]  srst, ssel;

   int checks = 0;
   int bad = 0;
   logic exp_owner = 1'b0;

   int irq_tot = 0, rst_tot = 0, selbad_tot = 0, flip_tot = 0, flip_rst_tot = 0;
   int rst_run = 0, rst_run_last = 0;
   logic prev_owner = 1'b0;

   always #4 clk = ~clk;

   swo_handover_ctrl #(.NSLOT(NSLOT), .TMR_W(TMR_W), .HOLD_W(HOLD_W)) u_dut (
      .clk(clk), .rst(rst), .req_i(req), .consent_i(consent),
      .timeout_cfg_i(tcfg), .hold_cfg_i(hcfg), .done_clr_i(dclr),
      .irq_o(irq), .slot_rst_o(srst), .slot_sel_o(ssel),
      .owner_o(owner), .last_forced_o(last_forced), .done_o(done)
   );

   always @(negedge clk) begin
      if (!rst) begin
         if (irq) irq_tot++;
         if (srst == ALL) begin
            rst_tot++;
            rst_run++;
         end else if (rst_run != 0) begin
            rst_run_last = rst_run;
            rst_run = 0;
         end
         if (ssel != ALL) selbad_tot++;
         if (owner != prev_owner) begin
            flip_tot++;
            if (srst == ALL) flip_rst_tot++;
         end
         prev_owner = owner;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic clear_done();
      @(negedge clk) dclr = 1'b1;
      @(negedge clk) dclr = 1'b0;
   endtask

   // k = wait cycle carrying consent (0 = none)
   task automatic handover(input string tag, input int n, input int h, input int k,
                           input bit extra_req, input bit exp_forced);
      int i0, r0, s0, f0, fr0, hq, waited;
      clear_done();
      tcfg = TMR_W'(n);
      hcfg = HOLD_W'(h);
      i0 = irq_tot; r0 = rst_tot; s0 = selbad_tot; f0 = flip_tot; fr0 = flip_rst_tot;
      @(negedge clk) req = 1'b1;
      @(negedge clk) req = 1'b0;
      chk({tag, " R2 irq raised"}, int'(irq), 1);
      @(negedge clk);
      if (extra_req) req = 1'b1;
      if (k > 0) begin
         repeat (k - 1) @(negedge clk);
         consent = 1'b1;
         @(negedge clk) consent = 1'b0;
      end
      @(negedge clk) req = 1'b0;
      waited = 0;
      while (!done && waited < 2000) begin
         @(negedge clk);
         waited++;
      end
      repeat (3) @(negedge clk);
      exp_owner = ~exp_owner;
      hq = (h < 1) ? 1 : h;
      chk({tag, " done set R9"}, int'(done), 1);
      chk({tag, " irq cycles R2"}, irq_tot - i0, (k > 0) ? k + 1 : n + 1);
      chk({tag, " class R3/R4"}, int'(last_forced), int'(exp_forced));
      chk({tag, " owner R3"}, int'(owner), int'(exp_owner));
      chk({tag, " single flip R8"}, flip_tot - f0, 1);
      chk({tag, " rst cycles R6"}, rst_tot - r0, hq + 1);
      chk({tag, " rst run R6"}, rst_run_last, hq + 1);
      chk({tag, " flip under rst R6"}, flip_rst_tot - fr0, 1);
      chk({tag, " sel held R7"}, selbad_tot - s0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 owner", int'(owner), 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 slot_rst", int'(srst), 0);
      chk("R1 slot_sel", int'(ssel), int'(ALL));
      chk("R1 done", int'(done), 0);
      chk("R1 last_forced", int'(last_forced), 0);
   endtask

   task automatic t_consent_ignored_idle();
      @(negedge clk) consent = 1'b1;
      repeat (4) @(negedge clk);
      consent = 1'b0;
      chk("R2 no irq without request", int'(irq), 0);
      chk("R8 owner unchanged idle", int'(owner), int'(exp_owner));
   endtask

   task automatic t_done_clear();
      int i;
      chk("R9 done still set", int'(done), 1);
      repeat (5) @(negedge clk);
      chk("R9 done sticky", int'(done), 1);
      @(negedge clk) dclr = 1'b1;
      @(negedge clk) dclr = 1'b0;
      chk("R9 done cleared", int'(done), 0);
      for (i = 0; i < 3; i++) @(negedge clk);
      chk("R9 done stays clear", int'(done), 0);
   endtask

   initial begin
      #(8 * 150000);
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 irq in reset", int'(irq), 0);
      rst = 1'b0;
      t_reset();
      t_consent_ignored_idle();
      handover("coop_mid",  8, 3, 2, 1'b0, 1'b0);   // R3
      handover("coop_last", 3, 1, 3, 1'b0, 1'b0);   // R4 boundary
      handover("forced",    5, 0, 0, 1'b0, 1'b1);   // R4
      handover("zero_tmo",  0, 2, 0, 1'b0, 1'b1);   // R5
      handover("busy_req",  6, 4, 0, 1'b1, 1'b1);   // R8
      t_done_clear();
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule